// File: doc/BRIEF.md
# Dual Word FIFO with Trigger-Level Requests

This block holds a transmit queue and a receive queue of 32-bit words, each entry carrying four data bytes, between a small register port and a serial engine. Software writes words into the transmit queue and reads words from the receive queue through a data register. The engine drains the transmit queue and fills the receive queue through a plain pop/push port.

A control register sets a trigger level for each direction and has a self-clearing flush bit per queue. A status register packs the free transmit slots and the valid receive words into two nibbles. Two level outputs request service when a queue crosses its trigger level. A push into a full transmit queue and a read from an empty receive queue are recorded in sticky error flags, which software clears by writing ones.

Register reads are combinational: `reg_rdata` follows `reg_addr` in the same cycle. A data read or write takes effect at the clock edge that ends the cycle.

Top module: `word_fifo_pair`

## Requirements
- R1: After reset both queues are empty. Status (address 1) reads 0x80, control (address 0) reads 0, and both error flags are 0. `tx_req` is 1 and `rx_req` is 0.
- R2: Words written to address 2 leave at `eng_tx_data` in write order. Words pushed by the engine are returned, in push order, by reads of address 2, and each such read pops one word.
- R3: Status bits 7:4 give the free transmit slots and bits 3:0 give the valid receive words, each saturating at 15.
- R4: `tx_req` is 1 exactly while free transmit slots are at least the transmit trigger plus one. The transmit trigger is control bits 7:5.
- R5: `rx_req` is 1 exactly while valid receive words are at least the receive trigger plus one. The receive trigger is control bits 4:2.
- R6: Writing 1 to control bit 1 (transmit) or bit 0 (receive) makes that bit read 1 for one cycle. At the next edge the queue is emptied and the bit clears by itself. A push or pop to the same queue at that edge is discarded.
- R7: A write to address 2 while the transmit queue holds DEPTH words is dropped and sets the sticky overflow flag (`tx_ovf_err`, error register bit 0).
- R8: A read of address 2 with the receive queue empty returns 0, pops nothing and sets the sticky underflow flag (`rx_udf_err`, error register bit 1).
- R9: Writing address 3 clears the overflow flag where data bit 0 is 1 and the underflow flag where data bit 1 is 1. A new error event in the same cycle wins over the clear.
- R10: An engine pop with the transmit queue empty has no effect, and `eng_tx_data` reads 0 while the queue is empty. An engine push with the receive queue full is dropped with no flag. `eng_tx_avail` and `eng_rx_space` show not-empty and not-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 2) |
| reg_addr | input | 2 | 0 control, 1 status, 2 data, 3 error flags |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tx_req | output | 1 | Transmit queue has room above its trigger |
| rx_req | output | 1 | Receive queue holds words above its trigger |
| tx_ovf_err | output | 1 | Sticky transmit overflow |
| rx_udf_err | output | 1 | Sticky receive underflow |
| eng_tx_pop | input | 1 | Engine takes the head transmit word |
| eng_tx_data | output | 32 | Head transmit word, 0 when empty |
| eng_tx_avail | output | 1 | Transmit queue is not empty |
| eng_rx_push | input | 1 | Engine stores a received word |
| eng_rx_data | input | 32 | Word stored by `eng_rx_push` |
| eng_rx_space | output | 1 | Receive queue is not full |

## Verification
The properties assume that `reg_wr` and `reg_rd` are never high together and that the data inputs are known whenever their strobe is high. The flush-clears properties also assume that nothing is pushed into a queue in the cycle its flush bit is pending. The random stimulus makes the register strobes mutually exclusive and sets flush bits only rarely. The bench model discards any push that meets a pending flush, so it matches the design even where the stimulus crosses that case. Directed runs fill both queues past full, read the empty receive queue, flush each direction, and place both trigger levels at their extreme values.

// File: rtl/wfp_pkg.sv
package wfp_pkg;

    localparam int ADDR_W   = 2;
    localparam int TRIG_W   = 3;
    localparam int NIB_W    = 4;
    localparam int NIB_MAX  = (1 << NIB_W) - 1;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_ERR  = 2'd3
    } reg_sel_e;

    // Control layout: tx trigger 7:5, rx trigger 4:2, tx flush 1, rx flush 0
    typedef struct packed {
        logic [TRIG_W-1:0] tx_trig;
        logic [TRIG_W-1:0] rx_trig;
        logic              tx_flush;
        logic              rx_flush;
    } ctrl_t;

    // Error layout: underflow 1, overflow 0
    typedef struct packed {
        logic rx_udf;
        logic tx_ovf;
    } err_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int ERR_W  = $bits(err_t);

    function automatic logic [NIB_W-1:0] sat_nib(input logic [15:0] n);
        return (n > 16'(NIB_MAX)) ? NIB_W'(NIB_MAX) : n[NIB_W-1:0];
    endfunction

    function automatic logic meets_trig(input logic [15:0] n,
                                        input logic [TRIG_W-1:0] t);
        return n >= ({{(16-TRIG_W){1'b0}}, t} + 16'd1);
    endfunction

endpackage

// File: rtl/wfp_fifo.sv
module wfp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

endmodule

// File: rtl/wfp_ctrl.sv
module wfp_ctrl
    import wfp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ovf_set,
    input  logic              udf_set,
    output ctrl_t             ctrl,
    output err_t              err
);

    logic  ctrl_wr, err_clr;
    err_t  clr_mask;

    assign ctrl_wr  = wr && (sel == SEL_CTRL);
    assign err_clr  = wr && (sel == SEL_ERR);
    assign clr_mask = err_clr ? err_t'(wdata[ERR_W-1:0]) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            err  <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            end else begin
                ctrl.tx_flush <= 1'b0;
                ctrl.rx_flush <= 1'b0;
            end
            err.tx_ovf <= ovf_set | (err.tx_ovf & ~clr_mask.tx_ovf);
            err.rx_udf <= udf_set | (err.rx_udf & ~clr_mask.rx_udf);
        end
    end

endmodule

// File: rtl/wfp_view.sv
module wfp_view
    import wfp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4
) (
    input  reg_sel_e          sel,
    input  ctrl_t             ctrl,
    input  err_t              err,
    input  logic [CNT_W-1:0]  tx_free,
    input  logic [CNT_W-1:0]  rx_used,
    input  logic [DATA_W-1:0] rx_head,
    input  logic              rx_empty,
    output logic [DATA_W-1:0] rdata,
    output logic              tx_req,
    output logic              rx_req
);

    logic [2*NIB_W-1:0] stat_word;

    assign stat_word = {sat_nib(16'(tx_free)), sat_nib(16'(rx_used))};
    assign tx_req    = meets_trig(16'(tx_free), ctrl.tx_trig);
    assign rx_req    = meets_trig(16'(rx_used), ctrl.rx_trig);

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CTRL: rdata[CTRL_W-1:0]  = ctrl;
            SEL_STAT: rdata[2*NIB_W-1:0] = stat_word;
            SEL_DATA: rdata              = rx_empty ? '0 : rx_head;
            SEL_ERR:  rdata[ERR_W-1:0]   = err;
            default:  rdata              = '0;
        endcase
    end

endmodule

// File: rtl/word_fifo_pair.sv
module word_fifo_pair
    import wfp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tx_req,
    output logic              rx_req,
    output logic              tx_ovf_err,
    output logic              rx_udf_err,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    output logic              eng_tx_avail,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic              eng_rx_space
);

    reg_sel_e          sel;
    ctrl_t             ctrl;
    err_t              err;
    logic              tx_push, rx_pop;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_flush_pend, rx_flush_pend;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt, tx_free;
    logic [DATA_W-1:0] tx_head, rx_head;

    assign sel           = reg_sel_e'(reg_addr);
    assign tx_push       = reg_wr && (sel == SEL_DATA);
    assign rx_pop        = reg_rd && (sel == SEL_DATA);
    assign tx_flush_pend = ctrl.tx_flush;
    assign rx_flush_pend = ctrl.rx_flush;
    assign tx_free       = CNT_W'(DEPTH) - tx_cnt;

    wfp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .flush     (tx_flush_pend),
        .push      (tx_push),
        .push_data (reg_wdata),
        .pop       (eng_tx_pop),
        .head      (tx_head),
        .count     (tx_cnt),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    wfp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .flush     (rx_flush_pend),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_cnt),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    wfp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .sel     (sel),
        .wdata   (reg_wdata),
        .ovf_set (tx_push && tx_full),
        .udf_set (rx_pop && rx_empty),
        .ctrl    (ctrl),
        .err     (err)
    );

    wfp_view #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_view (
        .sel      (sel),
        .ctrl     (ctrl),
        .err      (err),
        .tx_free  (tx_free),
        .rx_used  (rx_cnt),
        .rx_head  (rx_head),
        .rx_empty (rx_empty),
        .rdata    (reg_rdata),
        .tx_req   (tx_req),
        .rx_req   (rx_req)
    );

    assign tx_ovf_err   = err.tx_ovf;
    assign rx_udf_err   = err.rx_udf;
    assign eng_tx_data  = tx_empty ? '0 : tx_head;
    assign eng_tx_avail = !tx_empty;
    assign eng_rx_space = !rx_full;

endmodule

// File: rtl/word_fifo_pair_chk.sv
module word_fifo_pair_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              tx_ovf_err,
    input logic              rx_udf_err,
    input logic              eng_tx_pop,
    input logic [DATA_W-1:0] eng_tx_data,
    input logic              eng_tx_avail,
    input logic              tx_full,
    input logic              rx_empty,
    input logic              tx_flush_pend,
    input logic              rx_flush_pend
);

    // R6
    tx_flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        tx_flush_pend |=> !eng_tx_avail);

    // R6
    rx_flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        rx_flush_pend |=> rx_empty);

    // R6
    tx_flush_selfclear_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_flush_pend && !(reg_wr && reg_addr == 2'd0 && reg_wdata[1]))
        |=> !tx_flush_pend);

    // R7
    tx_overflow_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2 && tx_full) |=> tx_ovf_err);

    // R8
    rx_underflow_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd2 && rx_empty) |-> reg_rdata == '0);

    // R8
    rx_underflow_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd2 && rx_empty) |=> rx_udf_err);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_ovf_err && !(reg_wr && reg_addr == 2'd3 && reg_wdata[0]))
        |=> tx_ovf_err);

    // R9
    udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_udf_err && !(reg_wr && reg_addr == 2'd3 && reg_wdata[1]))
        |=> rx_udf_err);

    // R10
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_tx_pop && !eng_tx_avail) |-> eng_tx_data == '0);

endmodule

bind word_fifo_pair word_fifo_pair_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .tx_ovf_err    (tx_ovf_err),
    .rx_udf_err    (rx_udf_err),
    .eng_tx_pop    (eng_tx_pop),
    .eng_tx_data   (eng_tx_data),
    .eng_tx_avail  (eng_tx_avail),
    .tx_full       (tx_full),
    .rx_empty      (rx_empty),
    .tx_flush_pend (tx_flush_pend),
    .rx_flush_pend (rx_flush_pend)
);

// File: tb/word_fifo_pair_bench.sv
module word_fifo_pair_bench;

    localparam int DW    = 32;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          tx_req, rx_req, tx_ovf_err, rx_udf_err;
    logic          eng_tx_pop = 1'b0;
    logic [DW-1:0] eng_tx_data;
    logic          eng_tx_avail;
    logic          eng_rx_push = 1'b0;
    logic [DW-1:0] eng_rx_data = '0;
    logic          eng_rx_space;

    always #5 clk = ~clk;

    word_fifo_pair #(.DATA_W(DW), .DEPTH(DEPTH)) u_word_fifo_pair (
        .clk          (clk),
        .rst          (rst),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .tx_req       (tx_req),
        .rx_req       (rx_req),
        .tx_ovf_err   (tx_ovf_err),
        .rx_udf_err   (rx_udf_err),
        .eng_tx_pop   (eng_tx_pop),
        .eng_tx_data  (eng_tx_data),
        .eng_tx_avail (eng_tx_avail),
        .eng_rx_push  (eng_rx_push),
        .eng_rx_data  (eng_rx_data),
        .eng_rx_space (eng_rx_space)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] txq[$];
    logic [DW-1:0] rxq[$];
    logic [2:0]    m_txt = '0, m_rxt = '0;
    logic          m_txp = 1'b0, m_rxp = 1'b0, m_ovf = 1'b0, m_udf = 1'b0;

    task automatic chk(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] sat4(input int n);
        return (n > 15) ? 4'hF : 4'(n);
    endfunction

    function automatic logic [DW-1:0] exp_rdata(input logic [1:0] a);
        logic [DW-1:0] r;
        r = '0;
        case (a)
            2'd0: r[7:0] = {m_txt, m_rxt, m_txp, m_rxp};
            2'd1: r[7:0] = {sat4(DEPTH - txq.size()), sat4(rxq.size())};
            2'd2: r = (rxq.size() > 0) ? rxq[0] : '0;
            default: r[1:0] = {m_udf, m_ovf};
        endcase
        return r;
    endfunction

    function automatic string addr_tag(input logic [1:0] a);
        case (a)
            2'd0: return "R6";
            2'd1: return "R3";
            2'd2: return "R2/R8";
            default: return "R9";
        endcase
    endfunction

    task automatic step(input logic wr, input logic rd, input logic [1:0] a,
                        input logic [DW-1:0] wd, input logic ep,
                        input logic eu, input logic [DW-1:0] ed);
        bit tx_full_pre, rx_full_pre, rx_empty_pre, push_t, pop_r;
        bit novf, nudf;
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        eng_tx_pop = ep; eng_rx_push = eu; eng_rx_data = ed;
        #1;
        chk("R4", 32'(tx_req), 32'((DEPTH - txq.size()) >= int'(m_txt) + 1));
        chk("R5", 32'(rx_req), 32'(rxq.size() >= int'(m_rxt) + 1));
        chk("R7", 32'(tx_ovf_err), 32'(m_ovf));
        chk("R8", 32'(rx_udf_err), 32'(m_udf));
        chk("R10", 32'(eng_tx_avail), 32'(txq.size() > 0));
        chk("R10", 32'(eng_rx_space), 32'(rxq.size() < DEPTH));
        chk("R2", eng_tx_data, (txq.size() > 0) ? txq[0] : '0);
        chk(addr_tag(a), reg_rdata, exp_rdata(a));
        @(posedge clk);
        tx_full_pre  = (txq.size() == DEPTH);
        rx_full_pre  = (rxq.size() == DEPTH);
        rx_empty_pre = (rxq.size() == 0);
        push_t = wr && (a == 2'd2);
        pop_r  = rd && (a == 2'd2);
        novf = push_t && tx_full_pre;
        nudf = pop_r && rx_empty_pre;
        if (m_txp) txq.delete();
        else begin
            if (ep && txq.size() > 0) void'(txq.pop_front());
            if (push_t && !tx_full_pre) txq.push_back(wd);
        end
        if (m_rxp) rxq.delete();
        else begin
            if (pop_r && !rx_empty_pre) void'(rxq.pop_front());
            if (eu && !rx_full_pre) rxq.push_back(ed);
        end
        m_ovf = novf | (m_ovf & ~(wr && a == 2'd3 && wd[0]));
        m_udf = nudf | (m_udf & ~(wr && a == 2'd3 && wd[1]));
        if (wr && a == 2'd0) {m_txt, m_rxt, m_txp, m_rxp} = wd[7:0];
        else begin m_txp = 1'b0; m_rxp = 1'b0; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired, run did not complete");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state seen at the ports
        reg_addr = 2'd1; #1;
        chk("R1", reg_rdata, 32'h80);
        chk("R1", 32'(tx_req), 32'd1);
        chk("R1", 32'(rx_req), 32'd0);
        chk("R1", 32'(tx_ovf_err | rx_udf_err), 32'd0);
        reg_addr = 2'd0; #1;
        chk("R1", reg_rdata, 32'h0);

        // R7 fill transmit queue past full
        for (int i = 0; i < DEPTH + 2; i++)
            step(1, 0, 2'd2, 32'hA000_0000 + 32'(i), 0, 0, '0);
        step(0, 0, 2'd1, '0, 0, 0, '0);
        // R9 clear overflow, then R10 engine drains three words
        step(1, 0, 2'd3, 32'h1, 0, 0, '0);
        for (int i = 0; i < 3; i++) step(0, 0, 2'd3, '0, 1, 0, '0);
        // R4 high transmit trigger
        step(1, 0, 2'd0, 32'(7 << 5), 0, 0, '0);
        step(0, 0, 2'd1, '0, 0, 0, '0);
        // R6 transmit flush, read back pending then cleared
        step(1, 0, 2'd0, 32'((7 << 5) | 2), 0, 0, '0);
        step(0, 0, 2'd0, '0, 0, 0, '0);
        step(0, 0, 2'd0, '0, 0, 0, '0);
        step(0, 0, 2'd1, '0, 1, 0, '0);
        // R8 read empty receive queue
        step(0, 1, 2'd2, '0, 0, 0, '0);
        step(0, 0, 2'd3, '0, 0, 0, '0);
        // R5 receive trigger at top, engine overfills receive queue
        step(1, 0, 2'd0, 32'(7 << 2), 0, 0, '0);
        for (int i = 0; i < DEPTH + 2; i++)
            step(0, 0, 2'd1, '0, 0, 1, 32'hB000_0000 + 32'(i));
        step(0, 1, 2'd2, '0, 0, 0, '0);
        step(0, 1, 2'd2, '0, 0, 0, '0);
        // R6 receive flush
        step(1, 0, 2'd0, 32'h1, 0, 0, '0);
        step(0, 0, 2'd0, '0, 0, 0, '0);
        step(0, 0, 2'd1, '0, 0, 0, '0);
        step(1, 0, 2'd3, 32'h3, 0, 0, '0);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic [1:0]    a;
            logic [DW-1:0] wd;
            int            pick;
            bit            wr, rd;
            a    = 2'($urandom % 4);
            pick = int'($urandom % 10);
            wr   = (pick < 4);
            rd   = (pick >= 4 && pick < 8);
            wd   = $urandom;
            if (wr && a == 2'd0) begin
                wd = wd & 32'hFC;
                if ($urandom % 16 == 0) wd = wd | 32'($urandom % 4);
            end
            if (wr && a == 2'd3 && ($urandom % 4 != 0)) wd = '0;
            step(wr, rd, a, wd, ($urandom % 3 == 0), ($urandom % 3 == 0), $urandom);
        end

        finish_run();
    end

endmodule